// File: doc/BRIEF.md
# Sequential Integer Multiply and Divide Unit

This execution unit sits beside the integer pipeline of a 32-bit processor. It computes the eight multiply and divide operations of the standard integer extension one bit per clock. A single shift-and-add-or-subtract datapath serves every operation. Operand signs are taken off before the iteration starts and put back on at the end.

The pipeline pulses `start` together with a 3-bit operation code and two operands. The unit raises `busy` for the whole computation. When the answer is ready it pulses `done` for one clock, and the answer then stays on `result`.

Operands are copied when a start is accepted, so the pipeline may change its source buses at once. A new start may be given in the very cycle that `done` is high, which lets a high-half multiply and a low-half multiply on the same registers run back to back.

Top module: `muldiv_iter`

## Requirements
- R1: With `op` = 3'b000 the result is bits 31:0 of the product of `src_a` and `src_b`.
- R2: With `op` = 3'b001, 3'b010 and 3'b011 the result is bits 63:32 of the full product. For 001 both operands are signed. For 010 `src_a` is signed and `src_b` is unsigned. For 011 both are unsigned.
- R3: `op` = 3'b100 (signed) and 3'b101 (unsigned) return the quotient of `src_a` divided by `src_b`, truncated toward zero.
- R4: `op` = 3'b110 (signed) and 3'b111 (unsigned) return the remainder. A nonzero signed remainder carries the sign of `src_a`.
- R5: When `src_b` is zero, the quotient operations return 32'hFFFFFFFF and the remainder operations return `src_a`. No other signal reports the condition.
- R6: A signed divide of 32'h80000000 by 32'hFFFFFFFF returns 32'h80000000 as the quotient and 0 as the remainder.
- R7: `start` is accepted only while `busy` is low. A start pulse seen while `busy` is high has no effect on the running result or on its timing.
- R8: The operands and the code are captured at the accepting clock edge. Later changes on `src_a`, `src_b` or `op` do not affect that operation.
- R9: `busy` is high from the clock after acceptance until `done` rises. `done` rises 34 clocks after the accepting edge and lasts exactly one cycle. `result` changes only when `done` rises.
- R10: A start given in the cycle in which `done` is high is accepted.
- R11: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code (see R1 to R4) |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Latest completed result, held |

## Verification
Two functions can coincide in one cycle: completion of one operation and acceptance of the next. The bench raises `start` during the `done` cycle of a high-half multiply, requesting the low-half multiply on the same operands. It then checks three things: that the first result is intact, that `done` drops while `busy` rises on the next cycle, and that the second result arrives exactly 34 clocks later. A start pulse during `busy` is tested as well, and must leave both the value and the timing of the running operation untouched.

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          is_div, pick_hi, neg_main, neg_rem;
  logic [W-1:0]  hi, lo, dv;
  logic          done_q;
  logic [W-1:0]  res_q;

  wire accept = start && (st == S_IDLE);

  wire sgn_a = (op == 3'd1) || (op == 3'd2) || (op == 3'd4) || (op == 3'd6);
  wire sgn_b = (op == 3'd1) || (op == 3'd4) || (op == 3'd6);
  wire na = sgn_a && src_a[W-1];
  wire nb = sgn_b && src_b[W-1];
  wire [W-1:0] mag_a = na ? (~src_a + 1'b1) : src_a;
  wire [W-1:0] mag_b = nb ? (~src_b + 1'b1) : src_b;

  wire [W:0]   add_x = is_div ? {hi, lo[W-1]} : {1'b0, hi};
  wire [W:0]   add_y = is_div ? ~{1'b0, dv} : (lo[0] ? {1'b0, dv} : '0);
  wire [W+1:0] sum   = {1'b0, add_x} + {1'b0, add_y} + {{(W+1){1'b0}}, is_div};
  wire         fits  = sum[W+1];

  wire [2*W-1:0] prod  = {hi, lo};
  wire [2*W-1:0] prodn = ~prod + 1'b1;
  wire [2*W-1:0] psel  = neg_main ? prodn : prod;
  wire [W-1:0]   quo   = neg_main ? (~lo + 1'b1) : lo;
  wire [W-1:0]   rem   = neg_rem  ? (~hi + 1'b1) : hi;
  wire [W-1:0]   fin   = is_div ? (pick_hi ? rem : quo)
                                : (pick_hi ? psel[2*W-1:W] : psel[W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      is_div   <= 1'b0;
      pick_hi  <= 1'b0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      hi       <= '0;
      lo       <= '0;
      dv       <= '0;
      done_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          hi       <= '0;
          lo       <= mag_a;
          dv       <= mag_b;
          is_div   <= op[2];
          pick_hi  <= op[2] ? op[1] : (op[1:0] != 2'd0);
          neg_main <= op[2] ? ((na ^ nb) && (src_b != '0)) : (na ^ nb);
          neg_rem  <= na;
          cnt      <= '0;
          st       <= S_ITER;
        end
        S_ITER: begin
          if (is_div) begin
            hi <= fits ? sum[W-1:0] : add_x[W-1:0];
            lo <= {lo[W-2:0], fits};
          end else begin
            hi <= sum[W:1];
            lo <= {sum[0], lo[W-1:1]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FIX;
        end
        S_FIX: begin
          res_q  <= fin;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign result = res_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R9
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R9
  AST_BUSY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done)); // R7

endmodule

// File: tb/tb_muldiv_iter.sv
module tb_muldiv_iter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, done;
  logic [31:0] result;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  muldiv_iter #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b),
    .busy(busy), .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    case (o)
      3'd0: begin p = ua * ub; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFFFFFF;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return a;
        p = sa / sb; return p[31:0];
      end
      3'd5: begin if (b == 0) return 32'hFFFFFFFF; return a / b; end
      3'd6: begin
        if (b == 0) return a;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'd0;
        p = sa % sb; return p[31:0];
      end
      default: begin if (b == 0) return a; return a % b; end
    endcase
  endfunction

  // drives a start at a falling edge, scrambles the inputs, waits for done
  task automatic exec(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] r, output int lat);
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0; op = ~o; src_a = ~a; src_b = a ^ b ^ 32'h5A5A5A5A;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    r = result;
  endtask

  task automatic run_check(input string tag, input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    int lat;
    exec(o, a, b, r, lat);
    chk(tag, r, model(o, a, b));
    chk({tag, " latency R9"}, 32'(lat), 32'd34);
  endtask

  task automatic t_reset;
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 result", result, 32'd0);
  endtask

  task automatic t_mul;
    logic [31:0] va [6] = '{32'd7, 32'hFFFFFFFF, 32'h80000000, 32'h12345678, 32'hFFFFFFF9, 32'd0};
    logic [31:0] vb [6] = '{32'd9, 32'hFFFFFFFF, 32'h80000000, 32'h9ABCDEF0, 32'd3, 32'hDEADBEEF};
    for (int i = 0; i < 6; i++) begin
      run_check("R1 MUL", 3'd0, va[i], vb[i]);
      run_check("R2 MULH", 3'd1, va[i], vb[i]);
      run_check("R2 MULHSU", 3'd2, va[i], vb[i]);
      run_check("R2 MULHU", 3'd3, va[i], vb[i]);
    end
  endtask

  task automatic t_div;
    logic [31:0] va [6] = '{32'd100, 32'hFFFFFFF9, 32'd7, 32'hFFFFFFF9, 32'hFFFFFFFF, 32'h80000001};
    logic [31:0] vb [6] = '{32'd7, 32'd2, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'd1, 32'd3};
    for (int i = 0; i < 6; i++) begin
      run_check("R3 DIV", 3'd4, va[i], vb[i]);
      run_check("R3 DIVU", 3'd5, va[i], vb[i]);
      run_check("R4 REM", 3'd6, va[i], vb[i]);
      run_check("R4 REMU", 3'd7, va[i], vb[i]);
    end
    run_check("R3 DIV -7/2", 3'd4, 32'hFFFFFFF9, 32'd2);
    run_check("R4 REM -7%2", 3'd6, 32'hFFFFFFF9, 32'd2);
  endtask

  task automatic t_divzero;
    logic [31:0] r;
    int lat;
    exec(3'd4, 32'hFFFFFF00, 32'd0, r, lat); chk("R5 DIV/0", r, 32'hFFFFFFFF);
    exec(3'd5, 32'd12345, 32'd0, r, lat);    chk("R5 DIVU/0", r, 32'hFFFFFFFF);
    exec(3'd6, 32'hFFFFFF00, 32'd0, r, lat); chk("R5 REM/0", r, 32'hFFFFFF00);
    exec(3'd7, 32'd12345, 32'd0, r, lat);    chk("R5 REMU/0", r, 32'd12345);
  endtask

  task automatic t_overflow;
    logic [31:0] r;
    int lat;
    exec(3'd4, 32'h80000000, 32'hFFFFFFFF, r, lat); chk("R6 DIV ovf", r, 32'h80000000);
    exec(3'd6, 32'h80000000, 32'hFFFFFFFF, r, lat); chk("R6 REM ovf", r, 32'd0);
  endtask

  task automatic t_start_busy;
    int lat;
    @(negedge clk);
    start = 1'b1; op = 3'd4; src_a = 32'd1000; src_b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; op = 3'd0; src_a = 32'd3; src_b = 32'd3;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R7 result under busy start", result, 32'd142);
    chk("R7 latency under busy start", 32'(lat), 32'd34);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
    chk("R7 no second run", {31'd0, busy}, 32'd0);
    chk("R9 result held", result, 32'd142);
  endtask

  task automatic t_capture;
    logic [31:0] r;
    int lat;
    exec(3'd7, 32'd1000003, 32'd97, r, lat);
    chk("R8 operands captured", r, 32'd1000003 % 32'd97);
  endtask

  task automatic t_back_to_back;
    logic [31:0] a = 32'hF0000001, b = 32'h0FFFFFF3;
    int lat;
    @(negedge clk);
    start = 1'b1; op = 3'd1; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R2 MULH first of pair", result, model(3'd1, a, b));
    start = 1'b1; op = 3'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done dropped", {31'd0, done}, 32'd0);
    chk("R10 busy on accept in done cycle", {31'd0, busy}, 32'd1);
    lat = 1;
    repeat (10) begin @(negedge clk); lat++; end
    chk("R9 result held during next run", result, model(3'd1, a, b));
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R10 MUL second of pair", result, model(3'd0, a, b));
    chk("R10 latency second of pair", 32'(lat), 32'd34);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_div();
    t_divzero();
    t_overflow();
    t_start_busy();
    t_capture();
    t_back_to_back();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule